// File: doc/BRIEF.md
# Issue-Stepped Pipelined Multiplier

This unit multiplies two unsigned operands through a three-stage pipeline that moves only when a pipelined multiply is issued. An idle clock leaves every stage where it is. Each accepted pipelined issue loads its own operand pair into the first stage and returns, as its result, whatever leaves the last stage. A value therefore comes back only when the third following pipelined issue is made. Each stage carries a valid flag and an overflow flag along with its data.

An overflow that retires from the pipeline sets a sticky status bit. While that bit is set, any issue is refused and a trap pulse is raised instead. Only an explicit status-clear input drops the bit. A direct (non-pipelined) multiply returns its own product at once and empties every stage. Software uses it, or a run of dummy pipelined issues, to get rid of speculative contents left in flight.

Top module: `issue_step_mul`

## Requirements
- R1: After reset, all three stages are empty, and `status_o`, `res_valid_o`, `trap_o` and `res_o` are 0.
- R2: Stages advance only on an accepted pipelined issue (`issue_i`=1, `op_i`=0, status clear). Idle cycles do not move data. An operand pair's product is returned by the third accepted pipelined issue after it.
- R3: On the edge of an accepted pipelined issue, `res_valid_o` takes the last stage's valid flag. `res_o` takes that stage's data, or 0 if the stage is empty. An empty last stage never changes `status_o`.
- R4: A product is flagged as overflowing when it is 2^W or more. `res_o` then carries its low W bits. When a flagged entry retires, `status_o` is set.
- R5: An issue made while `status_o` is 1 produces a one-cycle `trap_o` pulse on the next edge. That issue does not execute, no stage moves, `res_valid_o` stays 0 and `res_o` is unchanged.
- R6: An accepted direct issue (`op_i`=1) returns its own product with `res_valid_o`=1 on the next edge and empties all stages. If its product overflows, it sets `status_o`.
- R7: `status_o` is sticky. It is cleared only by `clr_status_i`.
- R8: When `clr_status_i` and an overflow setting the status fall in the same cycle, `status_o` ends up set.
- R9: Without an accepted issue, `res_valid_o` is 0 and `res_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue request this cycle |
| op_i | input | 1 | 0 = pipelined multiply, 1 = direct multiply |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| clr_status_i | input | 1 | Clear sticky overflow status |
| res_o | output | W | Result value |
| res_valid_o | output | 1 | Result valid pulse |
| trap_o | output | 1 | Trap pulse for a refused issue |
| status_o | output | 1 | Sticky overflow status |

## Verification
The hardest case to reach is an overflow that retires in the same cycle that a clear is requested. It needs a flagged entry sitting in the last stage while the status bit is still clear. The stimulus first pushes an overflowing pair and then two filler issues, with idle cycles in between. It then makes the retiring issue with `clr_status_i` high. Trapped issues placed between pipelined ones confirm that the held stages come back intact once the status is cleared. A long random run mixes direct flushes, idle gaps and clears against a queue-based model.

// File: rtl/ism_pkg.sv
package ism_pkg;
  typedef enum logic {OP_PIPE = 1'b0, OP_DIRECT = 1'b1} op_e;
endpackage

// File: rtl/ism_mul_front.sv
module ism_mul_front #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_o,
  output logic         ovf_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  always_comb begin
    full   = PW'(a_i) * PW'(b_i);
    prod_o = full[W-1:0];
    ovf_o  = |full[PW-1:W];
  end
endmodule

// File: rtl/ism_stage_chain.sv
module ism_stage_chain #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             flush_i,
  input  logic [W-1:0]     in_data_i,
  input  logic             in_ovf_i,
  output logic             tail_vld_o,
  output logic [W-1:0]     tail_data_o,
  output logic             tail_ovf_o,
  output logic [DEPTH-1:0] vld_o
);
  typedef struct packed {
    logic         vld;
    logic         ovf;
    logic [W-1:0] data;
  } stage_t;

  stage_t st_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    stage_t feed;
    if (g == 0) begin : g_head
      assign feed = '{vld: 1'b1, ovf: in_ovf_i, data: in_data_i};
    end else begin : g_body
      assign feed = st_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g] <= '0;
      end else if (flush_i) begin
        st_q[g].vld <= 1'b0;
      end else if (adv_i) begin
        st_q[g] <= feed;
      end
    end

    assign vld_o[g] = st_q[g].vld;
  end

  assign tail_vld_o  = st_q[DEPTH-1].vld;
  assign tail_data_o = st_q[DEPTH-1].data;
  assign tail_ovf_o  = st_q[DEPTH-1].ovf;
endmodule

// File: rtl/ism_status.sv
module ism_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_o <= 1'b0;
    else if (set_i)  status_o <= 1'b1;
    else if (clr_i)  status_o <= 1'b0;
  end
endmodule

// File: rtl/issue_step_mul.sv
module issue_step_mul #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  input  logic         op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         clr_status_i,
  output logic [W-1:0] res_o,
  output logic         res_valid_o,
  output logic         trap_o,
  output logic         status_o
);
  import ism_pkg::*;

  logic [W-1:0]     prod;
  logic             prod_ovf;
  logic             accept, adv, flush, set_status;
  logic             tail_vld, tail_ovf;
  logic [W-1:0]     tail_data;
  logic [DEPTH-1:0] stage_vld;

  assign accept     = issue_i && !status_o;
  assign adv        = accept && (op_e'(op_i) == OP_PIPE);
  assign flush      = accept && (op_e'(op_i) == OP_DIRECT);
  assign set_status = (adv && tail_vld && tail_ovf) || (flush && prod_ovf);

  ism_mul_front #(.W(W)) u_front (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod),
    .ovf_o  (prod_ovf)
  );

  ism_stage_chain #(.W(W), .DEPTH(DEPTH)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .flush_i     (flush),
    .in_data_i   (prod),
    .in_ovf_i    (prod_ovf),
    .tail_vld_o  (tail_vld),
    .tail_data_o (tail_data),
    .tail_ovf_o  (tail_ovf),
    .vld_o       (stage_vld)
  );

  ism_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_status),
    .clr_i    (clr_status_i),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
      trap_o      <= 1'b0;
    end else begin
      trap_o      <= issue_i && status_o;
      res_valid_o <= adv ? tail_vld : flush;
      if (adv)        res_o <= tail_vld ? tail_data : '0;
      else if (flush) res_o <= prod;
    end
  end
endmodule

// File: rtl/ism_chk.sv
module ism_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_i,
  input logic             op_i,
  input logic             clr_status_i,
  input logic             res_valid_o,
  input logic             trap_o,
  input logic             status_o,
  input logic [W-1:0]     res_o,
  input logic [DEPTH-1:0] stage_vld
);
  // R5
  trap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && status_o |=> trap_o && !res_valid_o);
  // R5
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && status_o |=> $stable(stage_vld) && $stable(res_o));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !res_valid_o && !trap_o && $stable(res_o) && $stable(stage_vld));
  // R6
  direct_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !status_o && op_i |=> res_valid_o && (stage_vld == '0));
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o && !clr_status_i |=> status_o);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_i && !issue_i |=> !status_o);
endmodule

bind issue_step_mul ism_chk #(.W(W), .DEPTH(DEPTH)) u_ism_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_i      (issue_i),
  .op_i         (op_i),
  .clr_status_i (clr_status_i),
  .res_valid_o  (res_valid_o),
  .trap_o       (trap_o),
  .status_o     (status_o),
  .res_o        (res_o),
  .stage_vld    (stage_vld)
);

// File: tb/issue_step_mul_test.sv
module issue_step_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         issue_i = 1'b0;
  logic         op_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         clr_status_i = 1'b0;
  logic [W-1:0] res_o;
  logic         res_valid_o, trap_o, status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state: queue of in-flight entries, index 0 is the last stage
  int q_vld[$];
  int q_dat[$];
  int q_ovf[$];
  int e_res = 0, e_vld = 0, e_trap = 0, e_st = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  issue_step_mul #(.W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .clr_status_i(clr_status_i),
    .res_o(res_o), .res_valid_o(res_valid_o), .trap_o(trap_o), .status_o(status_o)
  );

  task automatic compare(string tag);
    n_cmp++;
    if (res_o !== W'(e_res) || res_valid_o !== e_vld[0] ||
        trap_o !== e_trap[0] || status_o !== e_st[0]) begin
      n_bad++;
      $display("FAIL %s: got res=%0d vld=%0d trap=%0d st=%0d exp res=%0d vld=%0d trap=%0d st=%0d",
               tag, res_o, res_valid_o, trap_o, status_o, e_res, e_vld, e_trap, e_st);
    end
  endtask

  task automatic model_reset();
    q_vld = {0, 0, 0}; q_dat = {0, 0, 0}; q_ovf = {0, 0, 0};
    e_res = 0; e_vld = 0; e_trap = 0; e_st = 0;
  endtask

  // drive at negedge, predict, then compare at the next negedge
  task automatic step(bit iss, bit op, int a, int b, bit clr, string tag);
    int p, set;
    issue_i = iss; op_i = op; a_i = W'(a); b_i = W'(b); clr_status_i = clr;
    set = 0;
    e_trap = (iss && e_st) ? 1 : 0;
    e_vld = 0;
    if (iss && !e_st) begin
      p = a * b;
      if (!op) begin
        e_vld = q_vld[0];
        e_res = q_vld[0] ? q_dat[0] : 0;
        set = q_vld[0] && q_ovf[0];
        void'(q_vld.pop_front()); void'(q_dat.pop_front()); void'(q_ovf.pop_front());
        q_vld.push_back(1); q_dat.push_back(p % 256); q_ovf.push_back(p > 255);
      end else begin
        e_vld = 1;
        e_res = p % 256;
        set = (p > 255);
        q_vld = {0, 0, 0};
      end
    end
    if (set) e_st = 1;
    else if (clr) e_st = 0;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic pipe(int a, int b, string tag); step(1, 0, a, b, 0, tag); endtask
  task automatic idle(string tag); step(0, 0, 0, 0, 0, tag); endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    // R2: fill with idle gaps, no result until third later issue
    pipe(2, 3, "R2 fill1");
    idle("R2 idle holds");
    pipe(4, 5, "R2 fill2");
    idle("R2 idle holds");
    idle("R2 idle holds");
    pipe(6, 7, "R3 empty tail no result");
    pipe(1, 1, "R2 first result 6");
    pipe(9, 9, "R2 second result 20");
    idle("R9 hold res");

    // R4: overflow retires and sets status
    pipe(20, 20, "R4 push ovf");
    pipe(2, 2, "R2 pipe");
    pipe(3, 3, "R2 pipe");
    pipe(1, 2, "R4 ovf retires sets status");
    pipe(5, 5, "R5 trapped issue");
    idle("R7 status sticky");
    step(1, 1, 3, 3, 0, "R5 trapped direct");
    step(0, 0, 0, 0, 1, "R7 clear");
    pipe(1, 3, "R5 held data resumes");
    pipe(1, 4, "R5 held data resumes");

    // R8: clear and overflow retirement same cycle
    pipe(16, 16, "R4 push ovf 256");
    pipe(1, 1, "R2 pipe");
    pipe(1, 1, "R2 pipe");
    step(1, 0, 1, 1, 1, "R8 set wins over clear");
    step(0, 0, 0, 0, 1, "R7 clear");

    // R6: direct flush and direct overflow
    pipe(2, 2, "R6 fill");
    pipe(3, 3, "R6 fill");
    step(1, 1, 7, 9, 0, "R6 direct 63");
    pipe(1, 1, "R6 flushed empty");
    pipe(1, 1, "R6 flushed empty");
    pipe(1, 1, "R6 flushed empty");
    pipe(1, 1, "R6 refilled result");
    step(1, 1, 17, 17, 0, "R6 direct ovf sets status");
    step(0, 0, 0, 0, 1, "R7 clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 75, r < 12, $urandom_range(0, 255), $urandom_range(0, 255) % ((r % 3 == 0) ? 256 : 16),
           $urandom_range(0, 9) == 0, "R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule